// File: doc/BRIEF.md
# Seconds and Milliseconds Time Counter with Shadow Latch

This block keeps wall-clock time as a seconds count plus a milliseconds count that runs from 0 to 999. The running counters advance on a millisecond step pulse supplied from outside. Bus readers never see the running counters directly. Once every eight pulses of a slow (32 kHz class) tick, the block opens a short busy window. At the end of that window it copies both counters into a register view on the bus side.

Software reads the milliseconds register first and then the shadow-seconds register. The milliseconds read loads the shadow register from the seconds view in the same clock, so the two values always belong to the same instant, even across a seconds rollover. Software sets the time by writing the seconds register, and that write also clears the milliseconds count. A write that lands inside the busy window is held and applied on the last clock of the window, so it is never lost. Both the step pulse and the slow tick arrive already synchronised to the bus clock.

Top module: `rtc_shadow_timer`

## Requirements
- R1: After reset, every register reads 0: busy (0x04), seconds (0x08), shadow seconds (0x0C) and milliseconds (0x10).
- R2: Each `ms_step` pulse advances the milliseconds count by one. From 999 it wraps to 0 and the seconds count goes up by one in the same clock.
- R3: On every eighth `slow_tick` pulse, the busy flag (bit 0 of offset 0x04) rises in the next clock and stays high for exactly BUSY_LEN (default 4) clocks. With one tick every 4 clocks, any 64 consecutive clocks therefore contain 8 busy clocks.
- R4: The seconds view (0x08) and the milliseconds view (0x10) change only on the last clock of a busy window. On that clock they take the running counters' values from before that edge.
- R5: A read of 0x10 loads the shadow register (0x0C) with the seconds view of the same clock. A milliseconds read followed by a shadow read therefore gives a consistent pair, and the value shadow*1000+ms never decreases while time runs.
- R6: A write to 0x08 while busy is 0 loads the running seconds with the written data and clears the running milliseconds on that clock edge.
- R7: A write to 0x08 while busy is 1 is held and applied on the last clock of the busy window. If several writes land in one window, the latest one wins.
- R8: Read data appears on `reg_rdata` the clock after `reg_rd`, and holds until the next read. The busy register's bits 31:1 read 0. Unmapped offsets read 0. Writes to any offset other than 0x08 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-clock pulse per slow time-base period |
| ms_step | input | 1 | One-clock pulse per elapsed millisecond |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | SEC_W | Write data |
| reg_rdata | output | SEC_W | Registered read data |

## Verification
A behavioural model in the bench predicts `reg_rdata` on every clock while reads sweep all offsets. This catches any view update that lands on the wrong clock of a busy window. The stimulus includes:
- a burst of exactly 1250 millisecond steps, which separates a correct 999-to-0 carry from an off-by-one wrap;
- back-to-back milliseconds and shadow read pairs across a seconds rollover, which expose a shadow load taken from the running counter instead of the view;
- two writes inside one busy window, which tell "held, latest wins" apart from dropped, early or first-wins behaviour;
- stray writes to read-only and unmapped offsets.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

  localparam int unsigned OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_BUSY   = 8'h04;
  localparam logic [OFS_W-1:0] OFS_SEC    = 8'h08;
  localparam logic [OFS_W-1:0] OFS_SHADOW = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_MSEC   = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BUSY,
    SEL_SEC,
    SEL_SHADOW,
    SEL_MSEC
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_BUSY:   return SEL_BUSY;
      OFS_SEC:    return SEL_SEC;
      OFS_SHADOW: return SEL_SHADOW;
      OFS_MSEC:   return SEL_MSEC;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned MS_W    = 10,
  parameter int unsigned MS_LAST = 999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_step,
  input  logic             load_en,
  input  logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] sec_q,
  output logic [MS_W-1:0]  ms_q
);

  localparam logic [MS_W-1:0] MS_END = MS_W'(MS_LAST);

  function automatic logic [MS_W-1:0] next_ms(input logic [MS_W-1:0] ms);
    return (ms == MS_END) ? '0 : ms + MS_W'(1);
  endfunction

  logic ms_wrap;
  assign ms_wrap = ms_step && !load_en && (ms_q == MS_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ms_q  <= '0;
    end else if (load_en) begin
      sec_q <= load_val;
      ms_q  <= '0;
    end else if (ms_step) begin
      ms_q <= next_ms(ms_q);
      if (ms_wrap) sec_q <= sec_q + SEC_W'(1);
    end
  end

  // R2
  a_r2_ms_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= MS_END);
  a_r2_wrap_carry: assert property (@(posedge clk) disable iff (!rst_n)
    ms_wrap |=> (ms_q == '0) && (sec_q == $past(sec_q) + SEC_W'(1)));
  // R6
  a_r6_load_apply: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (sec_q == $past(load_val)) && (ms_q == '0));

endmodule

// File: rtl/rtc_copy_seq.sv
module rtc_copy_seq #(
  parameter int unsigned PHASES   = 8,
  parameter int unsigned BUSY_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  output logic busy,
  output logic copy_start,
  output logic copy_end
);

  localparam int unsigned PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam int unsigned BC_W = $clog2(BUSY_LEN + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] phase_q;
  logic [BC_W-1:0] left_q;
  logic            busy_q;

  assign copy_start = slow_tick && (phase_q == PH_LAST) && !busy_q;
  assign copy_end   = busy_q && (left_q == '0);
  assign busy       = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (slow_tick) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (copy_start) begin
      busy_q <= 1'b1;
      left_q <= BC_W'(BUSY_LEN - 1);
    end else if (copy_end) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      left_q <= left_q - BC_W'(1);
    end
  end

  // checker-side run length of the busy window
  logic [BC_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy_q ? run_q + (BC_W+1)'(1) : '0;
  end

  // R3
  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (run_q == (BC_W+1)'(BUSY_LEN)));
  a_r3_start_rise: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |=> busy_q);

endmodule

// File: rtl/rtc_bus_view.sv
module rtc_bus_view
  import rtc_shadow_pkg::*;
#(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned MS_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [SEC_W-1:0] reg_wdata,
  input  logic             busy,
  input  logic             copy_end,
  input  logic [SEC_W-1:0] core_sec,
  input  logic [MS_W-1:0]  core_ms,
  output logic             load_en,
  output logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] reg_rdata
);

  reg_sel_e        sel;
  logic            wr_sec;
  logic            rd_ms;
  logic [SEC_W-1:0] view_sec, shadow_sec, pend_val, rd_mux;
  logic [MS_W-1:0]  view_ms;
  logic             pend_q;

  assign sel    = decode_ofs(reg_addr);
  assign wr_sec = reg_wr && (sel == SEL_SEC);
  assign rd_ms  = reg_rd && (sel == SEL_MSEC);

  // write gating: direct when idle, deferred to the window's last clock
  assign load_en  = (wr_sec && !busy) || (copy_end && (pend_q || wr_sec));
  assign load_val = wr_sec ? reg_wdata : pend_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_val <= '0;
    end else if (copy_end) begin
      pend_q   <= 1'b0;
    end else if (wr_sec && busy) begin
      pend_q   <= 1'b1;
      pend_val <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_sec <= '0;
      view_ms  <= '0;
    end else if (copy_end) begin
      view_sec <= core_sec;
      view_ms  <= core_ms;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_sec <= '0;
    else if (rd_ms) shadow_sec <= view_sec;
  end

  always_comb begin
    case (sel)
      SEL_BUSY:   rd_mux = {{(SEC_W-1){1'b0}}, busy};
      SEL_SEC:    rd_mux = view_sec;
      SEL_SHADOW: rd_mux = shadow_sec;
      SEL_MSEC:   rd_mux = {{(SEC_W-MS_W){1'b0}}, view_ms};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R4
  a_r4_view_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_end |=> $stable(view_sec) && $stable(view_ms));
  // R5
  a_r5_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ms |=> shadow_sec == $past(view_sec));
  // R6
  a_r6_load_gate: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (!busy || copy_end));
  // R7
  a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sec && busy && !copy_end) |=> pend_q);
  a_r7_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    copy_end |=> !pend_q);
  // R8
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: rtl/rtc_shadow_timer.sv
module rtc_shadow_timer
  import rtc_shadow_pkg::*;
#(
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned MS_W     = 10,
  parameter int unsigned MS_LAST  = 999,
  parameter int unsigned PHASES   = 8,
  parameter int unsigned BUSY_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             ms_step,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [SEC_W-1:0] reg_wdata,
  output logic [SEC_W-1:0] reg_rdata
);

  logic             busy, copy_start, copy_end, load_en;
  logic [SEC_W-1:0] load_val, core_sec;
  logic [MS_W-1:0]  core_ms;

  rtc_copy_seq #(.PHASES(PHASES), .BUSY_LEN(BUSY_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .busy(busy), .copy_start(copy_start), .copy_end(copy_end)
  );

  rtc_time_core #(.SEC_W(SEC_W), .MS_W(MS_W), .MS_LAST(MS_LAST)) u_core (
    .clk(clk), .rst_n(rst_n), .ms_step(ms_step),
    .load_en(load_en), .load_val(load_val),
    .sec_q(core_sec), .ms_q(core_ms)
  );

  rtc_bus_view #(.SEC_W(SEC_W), .MS_W(MS_W)) u_view (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .copy_end(copy_end),
    .core_sec(core_sec), .core_ms(core_ms),
    .load_en(load_en), .load_val(load_val), .reg_rdata(reg_rdata)
  );

  // R3: a new window only opens while idle
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> !busy);

endmodule

// File: tb/tb_rtc_shadow_timer.sv
module tb_rtc_shadow_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0, ms_step = 1'b0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;

  int total = 0, bad = 0;
  bit tick_en = 0;
  int tick_div = 0;
  int steps_left = 0;

  always #2 clk = ~clk;

  rtc_shadow_timer dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ms_step(ms_step),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // stimulus generators
  always @(negedge clk) begin
    tick_div++;
    slow_tick <= tick_en && (tick_div % 4 == 0);
    if (steps_left > 0) begin ms_step <= 1'b1; steps_left--; end
    else ms_step <= 1'b0;
  end

  // behavioural reference model
  logic [31:0] m_sec, m_view_sec, m_shadow, m_pend_val, m_rdata;
  int m_ms, m_view_ms, m_phase, m_left;
  bit m_pend;
  logic [7:0] m_last_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_ms = 0; m_view_sec = 0; m_view_ms = 0; m_shadow = 0;
      m_pend = 0; m_pend_val = 0; m_rdata = 0; m_phase = 0; m_left = 0;
      m_last_addr = 0;
    end else begin
      bit is_busy, is_end, wsec, do_load;
      logic [31:0] lval;
      logic [31:0] old_sec; int old_ms; logic [31:0] old_view;
      is_busy = m_left > 0;
      is_end  = m_left == 1;
      old_sec = m_sec; old_ms = m_ms; old_view = m_view_sec;
      if (reg_rd) begin
        m_last_addr = reg_addr;
        case (reg_addr)
          8'h04: m_rdata = {31'b0, is_busy};
          8'h08: m_rdata = m_view_sec;
          8'h0C: m_rdata = m_shadow;
          8'h10: m_rdata = m_view_ms;
          default: m_rdata = 0;
        endcase
        if (reg_addr == 8'h10) m_shadow = old_view;
      end
      wsec = reg_wr && reg_addr == 8'h08;
      do_load = 0; lval = 0;
      if (wsec && !is_busy) begin do_load = 1; lval = reg_wdata; end
      else if (is_end && (wsec || m_pend)) begin
        do_load = 1; lval = wsec ? reg_wdata : m_pend_val;
      end
      if (is_end) m_pend = 0;
      else if (wsec && is_busy) begin m_pend = 1; m_pend_val = reg_wdata; end
      if (is_end) begin m_view_sec = old_sec; m_view_ms = old_ms; end
      if (do_load) begin m_sec = lval; m_ms = 0; end
      else if (ms_step) begin
        if (m_ms == 999) begin m_ms = 0; m_sec = m_sec + 1; end
        else m_ms = m_ms + 1;
      end
      if (m_left > 0) m_left = m_left - 1;
      else if (slow_tick && m_phase == 7) m_left = 4;
      if (slow_tick) m_phase = (m_phase + 1) % 8;
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (reg_rdata !== m_rdata) begin
        bad++;
        case (m_last_addr)
          8'h04: $display("FAIL R3 busy read act=%h exp=%h", reg_rdata, m_rdata);
          8'h08, 8'h10: $display("FAIL R4 view read @%h act=%h exp=%h", m_last_addr, reg_rdata, m_rdata);
          8'h0C: $display("FAIL R5 shadow read act=%h exp=%h", reg_rdata, m_rdata);
          default: $display("FAIL R8 read @%h act=%h exp=%h", m_last_addr, reg_rdata, m_rdata);
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, ms_v, sh_v;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(8'h04, v); check("R1 busy", v, 0);
    rd(8'h08, v); check("R1 sec", v, 0);
    rd(8'h0C, v); check("R1 shadow", v, 0);
    rd(8'h10, v); check("R1 ms", v, 0);

    // R6 idle write
    wr(8'h08, 32'd100);
    tick_en = 1;
    idle(40);
    rd(8'h08, v); check("R6 sec load", v, 100);
    rd(8'h10, v); check("R6 ms clear", v, 0);

    // R2 exact step count: 1250 ms -> 101 s 250 ms
    steps_left = 1250;
    wait (steps_left == 0);
    idle(40);
    rd(8'h08, v); check("R2 sec carry", v, 101);
    rd(8'h10, v); check("R2 ms count", v, 250);

    // R5 consistent pairs across rollover
    begin
      longint prev_t = 0, t;
      bit mono_ok = 1, range_ok = 1;
      logic [31:0] first_sh = 0;
      steps_left = 2000;
      for (int i = 0; i < 400; i++) begin
        rd(8'h10, ms_v);
        rd(8'h0C, sh_v);
        if (i == 0) first_sh = sh_v;
        t = longint'(sh_v) * 1000 + ms_v;
        if (ms_v > 999) range_ok = 0;
        if (t < prev_t) mono_ok = 0;
        prev_t = t;
      end
      check("R5 pair monotonic", mono_ok, 1);
      check("R2 ms range", range_ok, 1);
      check("R5 rollover seen", (sh_v > first_sh), 1);
      wait (steps_left == 0);
    end

    // R7 writes inside one busy window: latest wins
    idle(40);
    while (m_left != 3) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'd500;
    @(negedge clk); reg_wdata = 32'd600;
    @(negedge clk); reg_wr = 1'b0;
    idle(40);
    rd(8'h08, v); check("R7 deferred write", v, 600);
    rd(8'h10, v); check("R7 ms cleared", v, 0);

    // R8 writes to other offsets have no effect
    wr(8'h10, 32'd77);
    wr(8'h0C, 32'd55);
    wr(8'h20, 32'd9);
    idle(40);
    rd(8'h10, v); check("R8 ms untouched", v, 0);
    rd(8'h08, v); check("R8 sec untouched", v, 600);
    rd(8'h20, v); check("R8 unmapped", v, 0);

    // R3 busy duty over 64 consecutive clocks
    begin
      int ones = 0;
      bit upper_ok = 1;
      @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h04;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        ones += reg_rdata[0];
        if (reg_rdata[31:1] != 0) upper_ok = 0;
      end
      reg_rd = 1'b0;
      check("R3 busy clocks", ones, 8);
      check("R8 busy upper bits", upper_ok, 1);
    end

    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule